// File: doc/BRIEF.md
# Timebase Interval Timer with Interrupt

A free-running prescaler counts every input clock. One of eight interval taps is picked through a one-byte control register. Each time the chosen interval completes, a sticky request flag is raised. An interrupt line follows the flag, gated by an enable bit in the same register. Software reads the register through a simple synchronous port. It drops the flag by writing a zero into the flag position, and a one written there leaves the flag alone.

The interval codes do not form one contiguous run. The three lowest codes pick short powers of two, and the remaining five pick a group of much longer ones. The two groups start at exponents set by parameters, with defaults of 11 and 22. Writes never reset the counter. A new interval code therefore takes effect on the existing count phase, with no restart.

Top module: `tbase_irq_timer`

## Requirements
- R1: After reset the flag, the enable and the interval code (bits 5:3) are all 0, so a read returns 8'h00 and `irq_o` is low.
- R2: Codes 0, 1 and 2 give intervals of 2^S, 2^(S+1) and 2^(S+2) clocks, where S is SHORT_EXP (default 11).
- R3: Codes 3 to 7 give intervals of 2^L to 2^(L+4) clocks, where L is LONG_EXP (default 22).
- R4: The flag (bit 7) is set on the clock edge at which the counter's low e bits wrap to zero, e being the selected exponent. It then stays set until it is cleared.
- R5: A register write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag unchanged.
- R6: `irq_o` is 1 exactly when both the flag and the enable (bit 6) are 1.
- R7: Bits 2:0 always read as 0, and values written to them have no effect.
- R8: When a flag-clearing write lands on the same edge as an interval completion, the flag ends up set.
- R9: The counter starts at 0 on reset, advances by one every clock and is never reset by register writes. A code change keeps the current count phase.
- R10: `reg_rdata_o` is 0 unless both `reg_sel_i` and `reg_rd_i` are 1. A write with `reg_sel_i` = 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; also the count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel_i | input | 1 | Address match for the control register |
| reg_wdata_i | input | 8 | Write data byte |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Read data (flag, enable, code, three zero bits) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag-clearing write that lands on the exact edge where the interval completes. The bench aligns to that edge from its own cycle count: it holds the write back until its model counter sits one clock before the wrap, then issues the write. The long taps would take millions of clocks at their default exponents. The bench therefore uses small SHORT_EXP and LONG_EXP values, which keeps the split between the two groups of taps while letting every code complete several intervals. Code changes are made partway through a count, so the kept phase is tested against the model's never-reset count.

// File: rtl/tbt_pkg.sv
// Shared definitions for the timebase interval timer.
// Assumes the interval code is three bits: codes 0..2 use the short tap group,
// and codes 3..7 use the long group.
package tbt_pkg;

    typedef logic [2:0] ivl_code_t;

    localparam int unsigned NUM_CODES = 8;
    localparam int unsigned SHORT_CODES = 3;

    // Bit positions inside the control byte
    localparam int unsigned B_FLAG = 7;
    localparam int unsigned B_EN = 6;
    localparam int unsigned B_CODE_LO = 3;

    // Interval exponent for a given code
    function automatic int unsigned code_exp(input int unsigned code,
                                             input int unsigned short_exp,
                                             input int unsigned long_exp);
        if (code < SHORT_CODES)
            return short_exp + code;
        return long_exp + (code - SHORT_CODES);
    endfunction

endpackage

// File: rtl/tbt_counter.sv
// Free-running prescaler counter.
// It clears only on reset and then wraps naturally at 2^CNT_W.
// Assumes CNT_W covers the largest interval exponent.
module tbt_counter #(
    parameter int unsigned CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o
);

    // Advance the count by one every clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else
            cnt_o <= cnt_o + 1'b1;
    end

endmodule

// File: rtl/tbt_tap_sel.sv
// Interval tap selection.
// For each code it flags the clock whose edge wraps the low e bits of the
// counter to zero. It then forwards the flag of the selected code.
// Assumes the largest exponent is no greater than CNT_W.
module tbt_tap_sel
    import tbt_pkg::*;
#(
    parameter int unsigned CNT_W     = 26,
    parameter int unsigned SHORT_EXP = 11,
    parameter int unsigned LONG_EXP  = 22
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  ivl_code_t        code_i,
    output logic             tick_o
);

    logic [NUM_CODES-1:0] wrap_pend;

    // One low-bit mask comparator per code
    for (genvar c = 0; c < NUM_CODES; c++) begin : g_tap
        localparam int unsigned EXP = code_exp(c, SHORT_EXP, LONG_EXP);
        localparam logic [CNT_W-1:0] MASK = {CNT_W{1'b1}} >> (CNT_W - EXP);
        assign wrap_pend[c] = ((cnt_i & MASK) == MASK);
    end

    // Forward the comparator of the selected code
    always_comb begin
        tick_o = wrap_pend[code_i];
    end

endmodule

// File: rtl/tbt_ctrl_reg.sv
// Control register: sticky request flag, interrupt enable and interval code.
// Writing 0 to bit 7 clears the flag, and writing 1 there has no effect.
// On the same edge, an interval completion wins over a clear. Bits 2:0 read 0.
module tbt_ctrl_reg
    import tbt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_i,
    input  logic [7:0] wdata_i,
    input  logic       wr_i,
    input  logic       rd_i,
    input  logic       tick_i,
    output logic [7:0] rdata_o,
    output ivl_code_t  code_o,
    output logic       flag_o,
    output logic       en_o,
    output logic       irq_o
);

    logic wr_hit;
    logic clr_req;

    // Decode an addressed write and a clear request
    always_comb begin
        wr_hit  = sel_i && wr_i;
        clr_req = wr_hit && !wdata_i[B_FLAG];
    end

    // Enable and interval code take the written value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            code_o <= '0;
        end else if (wr_hit) begin
            en_o   <= wdata_i[B_EN];
            code_o <= wdata_i[B_CODE_LO +: 3];
        end
    end

    // Sticky flag: set on completion, cleared only by a zero write
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (tick_i)
            flag_o <= 1'b1;
        else if (clr_req)
            flag_o <= 1'b0;
    end

    // Read mux and interrupt gate
    always_comb begin
        rdata_o = (sel_i && rd_i) ? {flag_o, en_o, code_o, 3'b000} : 8'h00;
        irq_o   = flag_o && en_o;
    end

endmodule

// File: rtl/tbase_irq_timer.sv
// Top level of the timebase interval timer.
// Connects the counter, the tap selector and the control register.
// Assumes LONG_EXP lies above SHORT_EXP + 2, so the two tap groups stay apart.
module tbase_irq_timer
    import tbt_pkg::*;
#(
    parameter int unsigned SHORT_EXP = 11,
    parameter int unsigned LONG_EXP  = 22
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_sel_i,
    input  logic [7:0] reg_wdata_i,
    input  logic       reg_wr_i,
    input  logic       reg_rd_i,
    output logic [7:0] reg_rdata_o,
    output logic       irq_o
);

    localparam int unsigned CNT_W = LONG_EXP + (NUM_CODES - SHORT_CODES) - 1;

    logic [CNT_W-1:0] cnt;
    logic             tick;
    ivl_code_t        code;
    logic             flag;
    logic             en;

    tbt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt)
    );

    tbt_tap_sel #(
        .CNT_W     (CNT_W),
        .SHORT_EXP (SHORT_EXP),
        .LONG_EXP  (LONG_EXP)
    ) u_tap (
        .cnt_i  (cnt),
        .code_i (code),
        .tick_o (tick)
    );

    tbt_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .wr_i    (reg_wr_i),
        .rd_i    (reg_rd_i),
        .tick_i  (tick),
        .rdata_o (reg_rdata_o),
        .code_o  (code),
        .flag_o  (flag),
        .en_o    (en),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/tbase_irq_timer_chk.sv
// Property checker for the timebase interval timer, bound to the top level.
// It observes the ports together with the counter, the tick, the flag and the enable.
module tbase_irq_timer_chk #(
    parameter int unsigned CNT_W = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_i,
    input logic [7:0]       wdata_i,
    input logic             wr_i,
    input logic             rd_i,
    input logic [7:0]       rdata_i,
    input logic             irq_i,
    input logic [CNT_W-1:0] cnt,
    input logic             tick,
    input logic             flag,
    input logic             en
);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |-> (flag && en)); // R6

    AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> flag); // R8

    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && sel_i && wr_i && !wdata_i[7]) |=> !flag); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(sel_i && wr_i && !wdata_i[7])) |=> flag); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != {CNT_W{1'b1}}) |=> (cnt == $past(cnt) + 1'b1)); // R9

    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && rd_i) |-> (rdata_i[2:0] == 3'b000)); // R7

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && rd_i) |-> (rdata_i == 8'h00)); // R10

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && wr_i) |=> $stable(en)); // R10

endmodule

bind tbase_irq_timer tbase_irq_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .rdata_i (reg_rdata_o),
    .irq_i   (irq_o),
    .cnt     (cnt),
    .tick    (tick),
    .flag    (flag),
    .en      (en)
);

// File: tb/tbase_irq_timer_test.sv
// Bench: a behavioural model (integer count, bit flags) checked against the design at every negative edge.
module tbase_irq_timer_test;

    localparam int unsigned S_EXP = 4;
    localparam int unsigned L_EXP = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int  compared = 0;
    int  mismatched = 0;
    int  cycles = 0;
    bit  started = 0;
    string phase = "R1";

    longint m_cnt = 0;
    bit     m_flag = 0;
    bit     m_en = 0;
    int     m_code = 0;

    tbase_irq_timer #(.SHORT_EXP(S_EXP), .LONG_EXP(L_EXP)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_sel_i   (sel),
        .reg_wdata_i (wdata),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    always #2 clk = ~clk;

    function automatic longint period_of(input int code);
        int e;
        e = (code < 3) ? (S_EXP + code) : (L_EXP + code - 3);
        return longint'(1) << e;
    endfunction

    // Model update on each rising edge (the bench changes inputs 1 ns after it)
    always @(posedge clk) begin
        bit tk;
        started = 1;
        if (!rst_n) begin
            m_cnt = 0; m_flag = 0; m_en = 0; m_code = 0;
        end else begin
            tk = ((m_cnt % period_of(m_code)) == period_of(m_code) - 1);
            if (tk) m_flag = 1;
            else if (sel && wr && !wdata[7]) m_flag = 0;
            if (sel && wr) begin
                m_en = wdata[6];
                m_code = int'(wdata[5:3]);
            end
            m_cnt = m_cnt + 1;
        end
    end

    // Compare the outputs at every falling edge
    always @(negedge clk) begin
        logic [7:0] exp_rd;
        if (started) begin
            exp_rd = (sel && rd) ? {m_flag, m_en, 3'(m_code), 3'b000} : 8'h00;
            compared++;
            if (rdata !== exp_rd) begin
                mismatched++;
                $display("FAIL %s rdata=%h expected=%h at cycle %0d", phase, rdata, exp_rd, cycles);
            end
            compared++;
            if (irq !== (m_flag && m_en)) begin
                mismatched++;
                $display("FAIL %s irq=%b expected=%b at cycle %0d", phase, irq, m_flag && m_en, cycles);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic reg_write(input logic s, input logic [7:0] d);
        @(posedge clk); #1;
        sel = s; wr = 1'b1; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0; sel = 1'b1;
    endtask

    function automatic logic [7:0] ctl(input bit f, input bit e, input int c);
        return {f, e, 3'(c), 3'b000};
    endfunction

    initial begin
        longint p;
        // R1: reset state, register read while reset is held and after release
        sel = 1'b1; rd = 1'b1;
        step(4);
        rst_n = 1'b1;
        step(3);

        // R2: the short codes, each run over several intervals with reads active
        phase = "R2";
        for (int c = 0; c < 3; c++) begin
            reg_write(1'b1, ctl(1'b0, 1'b1, c));
            step(int'(3 * period_of(c)));
        end

        // R3: the long codes, each changed partway through a count (R9: phase is kept)
        phase = "R3";
        for (int c = 3; c < 8; c++) begin
            reg_write(1'b1, ctl(1'b0, 1'b1, c));
            step(int'(2 * period_of(c) + 37));
        end
        phase = "R9";
        reg_write(1'b1, ctl(1'b0, 1'b1, 1));
        step(50);
        reg_write(1'b1, ctl(1'b0, 1'b1, 4));
        step(int'(period_of(4)));

        // R5: a write with bit 7 = 1 keeps the flag, and a write with bit 7 = 0 clears it
        phase = "R5";
        reg_write(1'b1, ctl(1'b0, 1'b1, 0));
        step(int'(period_of(0)));
        reg_write(1'b1, ctl(1'b1, 1'b1, 3));
        step(2);
        reg_write(1'b1, ctl(1'b0, 1'b1, 3));
        step(5);

        // R6: the flag is set but the enable is off, so irq stays low
        phase = "R6";
        reg_write(1'b1, ctl(1'b1, 1'b0, 0));
        step(int'(2 * period_of(0)));
        reg_write(1'b1, ctl(1'b1, 1'b1, 0));
        step(3);

        // R7: writes to the low bits are ignored, and the low bits read as zero
        phase = "R7";
        reg_write(1'b1, 8'h47);
        step(3);
        reg_write(1'b1, 8'h05);
        step(3);

        // R10: an unaddressed write or read has no effect
        phase = "R10";
        reg_write(1'b1, ctl(1'b1, 1'b1, 2));
        step(int'(period_of(2)) + 2);
        reg_write(1'b0, 8'h00);
        step(2);
        sel = 1'b0; step(3);
        rd = 1'b0; sel = 1'b1; step(3);
        rd = 1'b1; step(2);

        // R8: a clear write issued on the edge where the interval completes
        phase = "R8";
        reg_write(1'b1, ctl(1'b1, 1'b1, 1));
        p = period_of(1);
        for (int k = 0; k < 3; k++) begin
            while ((m_cnt % p) != p - 1) step(1);
            sel = 1'b1; wr = 1'b1; wdata = ctl(1'b0, 1'b1, 1);
            @(posedge clk); #1;
            wr = 1'b0;
            step(3);
        end
        // R4: the flag stays set with no clear
        phase = "R4";
        step(int'(3 * p));

        // R1: reset applied again in mid-operation
        phase = "R1";
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule